// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a serial slave that lets a host processor configure the chip over a four-wire serial link. The host pulls the active-low latch line low, clocks in one 16-bit command frame MSB first on rising serial clock edges, and raises the latch line again. If exactly 16 bits were received, that rising edge commits the frame. A frame either writes one of eleven 10-bit configuration registers or reads back any register on the serial output line within the same frame.

The configuration registers drive the rest of the chip in parallel through one flat vector, with register k at bits `[10k+9:10k]`. Two further addresses return 6-bit status values supplied from outside. When such a read completes, the block pulses a strobe that carries the address, so that the status source can clear its value once it has been read. All serial inputs are synchronised into the system clock domain and sampled there. The serial clock therefore has to run well below the system clock.

Top module: `spi_cfg_regfile`

## Requirements
- R1: After reset, configuration registers 2 to 7 (the volume registers) hold 0x3FF (no attenuation) and registers 0, 1 and 8 to 10 hold 0, on `cfg_o`.
- R2: A frame is 16 bits sent MSB first: bits 15:12 address, bit 11 direction (0 = write, 1 = read), bit 10 reserved, bits 9:0 data. A write frame to address 0 to 10 updates that register on `cfg_o` after the latch line rises. No other register changes.
- R3: A frame of fewer or more than 16 bits is discarded when the latch line rises. It causes no write and no read strobe.
- R4: A frame with reserved bit 10 set is discarded. A write does not update any register. A read gives no strobe and drives no data on `spi_miso`.
- R5: A write frame to the status addresses 11 and 12, or to the unused addresses 13 to 15, leaves all configuration registers unchanged. A later read of address 11 still returns status.
- R6: During a read frame, `spi_miso` carries the addressed 10-bit value MSB first. Bit 9 is valid at the 7th rising serial clock edge and bit 0 at the 16th. A read does not alter any configuration register.
- R7: A read of address 11 or 12 returns the matching 6-bit status input in bits 9:4, with bits 3:0 zero. A read of addresses 13 to 15 returns 0.
- R8: A valid 16-bit read frame produces a single-cycle `rd_strobe_o` pulse with `rd_addr_o` equal to the frame address. Writes and rejected frames produce no pulse.
- R9: `spi_miso` is low during write frames and while the latch line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_latch_n | input | 1 | Active-low frame latch; a rising edge ends the frame |
| spi_mosi | input | 1 | Serial command data, MSB first |
| spi_miso | output | 1 | Serial readback data |
| stat0_i | input | 6 | Status value returned at address 11 |
| stat1_i | input | 6 | Status value returned at address 12 |
| cfg_o | output | 110 | All configuration registers, register k at bits 10k+9:10k |
| rd_strobe_o | output | 1 | One-cycle pulse after a valid read frame |
| rd_addr_o | output | 4 | Address of the last valid read frame |

## Verification
Writes are tried with all-ones, all-zeros and alternating data patterns, at the lowest, highest and a middle configuration address. A following full readback separates a wrong address decode from a wrong bit order on `spi_miso`. Frames of 15 and 17 bits check that commit depends on an exact bit count and not merely on the latch edge. Reserved-bit frames, writes to the status and unused slots, and status reads with different 6-bit patterns distinguish a correct read-only guard and MSB alignment from a design that drops the status value into the low bits or lets a write reach it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int FRAME_W    = 16;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 10;
  localparam int STAT_W     = 6;
  localparam int NUM_CFG    = 11;
  localparam int STAT0_ADDR = 11;
  localparam int STAT1_ADDR = 12;
  localparam int VOL_LO     = 2;
  localparam int VOL_HI     = 7;
  // header = address + direction + reserved
  localparam int HDR_BITS   = ADDR_W + 2;
  localparam int PAD_W      = DATA_W - STAT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsv;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [DATA_W-1:0] cfg_reset_val(input int idx);
    return (idx >= VOL_LO && idx <= VOL_HI) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= RST_VAL;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              latch_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              commit_wr,
  output logic              commit_rd,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [DATA_W-1:0] frm_data,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_d_q, latch_d_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               rd_on_q, rd_on_d;
  logic [DATA_W-1:0]  dout_q, dout_d;
  logic               strobe_q, strobe_d;
  logic [ADDR_W-1:0]  raddr_q, raddr_d;

  logic   sclk_rise, latch_rise, active, hdr_done, full;
  frame_t frm;

  always_comb begin
    sclk_rise  = sclk_s & ~sclk_d_q;
    latch_rise = latch_n_s & ~latch_d_q;
    active     = ~latch_n_s;
    // the sixth bit is arriving now: address and direction already stored
    hdr_done   = active & sclk_rise & (cnt_q == CNT_W'(HDR_BITS - 1));
    hdr_addr   = shreg_q[HDR_BITS-2 -: ADDR_W];
    frm        = frame_t'(shreg_q);
    full       = latch_rise & (cnt_q == CNT_W'(FRAME_W));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (sclk_rise && cnt_q != CNT_W'(CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end

    shreg_d = shreg_q;
    if (active && sclk_rise) begin
      shreg_d = {shreg_q[FRAME_W-2:0], mosi_s};
    end

    rd_on_d = rd_on_q;
    dout_d  = dout_q;
    if (!active) begin
      rd_on_d = 1'b0;
      dout_d  = '0;
    end else if (hdr_done) begin
      rd_on_d = shreg_q[0] & ~mosi_s;
      dout_d  = rd_data;
    end else if (sclk_rise && rd_on_q && cnt_q >= CNT_W'(HDR_BITS)) begin
      dout_d = {dout_q[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    commit_wr = full & ~frm.rsv & ~frm.rd;
    commit_rd = full & ~frm.rsv & frm.rd;
    frm_addr  = frm.addr;
    frm_data  = frm.data;
    strobe_d  = commit_rd;
    raddr_d   = commit_rd ? frm.addr : raddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q  <= 1'b0;
      latch_d_q <= 1'b1;
      cnt_q     <= '0;
      shreg_q   <= '0;
      rd_on_q   <= 1'b0;
      dout_q    <= '0;
      strobe_q  <= 1'b0;
      raddr_q   <= '0;
    end else begin
      sclk_d_q  <= sclk_s;
      latch_d_q <= latch_n_s;
      cnt_q     <= cnt_d;
      shreg_q   <= shreg_d;
      rd_on_q   <= rd_on_d;
      dout_q    <= dout_d;
      strobe_q  <= strobe_d;
      raddr_q   <= raddr_d;
    end
  end

  assign miso      = rd_on_q & dout_q[DATA_W-1];
  assign rd_strobe = strobe_q;
  assign rd_addr   = raddr_q;

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [STAT_W-1:0]         stat0,
  input  logic [STAT_W-1:0]         stat1,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat,
  output logic [DATA_W-1:0]         rd_data
);

  logic [DATA_W-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [DATA_W-1:0] RST = cfg_reset_val(g);
    logic              hit;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      hit = wr_en & (wr_addr == ADDR_W'(g));
      nxt = hit ? wr_data : cfg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= RST;
      end else begin
        cfg_q[g] <= nxt;
      end
    end

    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (rd_addr == ADDR_W'(k)) begin
        rd_data = cfg_q[k];
      end
    end
    if (rd_addr == ADDR_W'(STAT0_ADDR)) begin
      rd_data = {stat0, {PAD_W{1'b0}}};
    end else if (rd_addr == ADDR_W'(STAT1_ADDR)) begin
      rd_data = {stat1, {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      arst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_latch_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  input  logic [STAT_W-1:0]         stat0_i,
  input  logic [STAT_W-1:0]         stat1_i,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o,
  output logic                      rd_strobe_o,
  output logic [ADDR_W-1:0]         rd_addr_o
);

  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] hdr_addr, frm_addr;
  logic [DATA_W-1:0] frm_data, rd_data;
  logic              commit_wr, commit_rd;

  spi_cfg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (1'b1),
    .q     (rst_n_s)
  );

  // order: serial clock, latch, data
  spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({spi_sclk, spi_latch_n, spi_mosi}),
    .q     (pins_s)
  );

  spi_cfg_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk_s    (pins_s[2]),
    .latch_n_s (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .rd_data   (rd_data),
    .hdr_addr  (hdr_addr),
    .commit_wr (commit_wr),
    .commit_rd (commit_rd),
    .frm_addr  (frm_addr),
    .frm_data  (frm_data),
    .rd_strobe (rd_strobe_o),
    .rd_addr   (rd_addr_o),
    .miso      (spi_miso)
  );

  spi_cfg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (commit_wr),
    .wr_addr  (frm_addr),
    .wr_data  (frm_data),
    .rd_addr  (hdr_addr),
    .stat0    (stat0_i),
    .stat1    (stat1_i),
    .cfg_flat (cfg_o),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/spi_cfg_regfile_chk.sv
module spi_cfg_regfile_chk
  import spi_cfg_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      spi_latch_n,
  input logic                      spi_miso,
  input logic                      commit_wr,
  input logic                      commit_rd,
  input logic [NUM_CFG*DATA_W-1:0] cfg_o,
  input logic                      rd_strobe
);

  // R5: configuration moves only on a committed write
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_wr |=> $stable(cfg_o));

  // R8: strobe lasts a single cycle
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  // R8: strobe only follows a committed read
  p_strobe_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(commit_rd));

  // R9: serial output quiet once the latch line has been high a while
  p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_latch_n && $past(spi_latch_n) && $past(spi_latch_n, 2) && $past(spi_latch_n, 3))
      |=> !spi_miso);

  // R2: a write commit and a read strobe never coincide
  p_no_wr_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_wr && rd_strobe));

endmodule

bind spi_cfg_regfile spi_cfg_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .spi_latch_n (spi_latch_n),
  .spi_miso    (spi_miso),
  .commit_wr   (commit_wr),
  .commit_rd   (commit_rd),
  .cfg_o       (cfg_o),
  .rd_strobe   (rd_strobe_o)
);

// File: tb/spi_cfg_regfile_tb.sv
module spi_cfg_regfile_tb;
  import spi_cfg_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_SCLK  = 4;

  logic clk, arst_n, sclk, latch_n, mosi, miso, rd_strobe;
  logic [STAT_W-1:0] stat0, stat1;
  logic [NUM_CFG*DATA_W-1:0] cfg;
  logic [ADDR_W-1:0] rd_addr;

  int n_chk = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] model [NUM_CFG];
  logic [DATA_W-1:0] exp_rd_q[$];
  logic [DATA_W-1:0] got_rd_q[$];
  logic [ADDR_W-1:0] exp_strb_q[$];

  spi_cfg_regfile u_dut (
    .clk(clk), .arst_n(arst_n), .spi_sclk(sclk), .spi_latch_n(latch_n),
    .spi_mosi(mosi), .spi_miso(miso), .stat0_i(stat0), .stat1_i(stat1),
    .cfg_o(cfg), .rd_strobe_o(rd_strobe), .rd_addr_o(rd_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_CFG*DATA_W-1:0] model_flat();
    logic [NUM_CFG*DATA_W-1:0] f;
    for (int i = 0; i < NUM_CFG; i++) f[i*DATA_W +: DATA_W] = model[i];
    return f;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives n bits of frm MSB first; bits beyond 16 are zero
  task automatic xfer(input logic [FRAME_W-1:0] frm, input int n,
                      output logic [DATA_W-1:0] rx, output logic seen);
    rx = '0;
    seen = 1'b0;
    latch_n = 1'b0;
    wclk(HALF_SCLK);
    for (int i = 0; i < n; i++) begin
      mosi = (i < FRAME_W) ? frm[FRAME_W-1-i] : 1'b0;
      wclk(HALF_SCLK);
      sclk = 1'b1;
      seen = seen | miso;
      if (i >= HDR_BITS && i < FRAME_W) rx = {rx[DATA_W-2:0], miso};
      wclk(HALF_SCLK);
      sclk = 1'b0;
    end
    wclk(HALF_SCLK);
    latch_n = 1'b1;
    wclk(8);
  endtask

  task automatic do_write(input string req, input int addr, input logic [DATA_W-1:0] data,
                          input logic rsv, input int n);
    logic [DATA_W-1:0] rx;
    logic seen;
    xfer({ADDR_W'(addr), 1'b0, rsv, data}, n, rx, seen);
    if (n == FRAME_W && !rsv && addr < NUM_CFG) model[addr] = data;
    check({req, " miso low in write (R9)"}, 128'(seen), 128'(0));
    check({req, " cfg_o"}, 128'(cfg), 128'(model_flat()));
  endtask

  task automatic do_read(input int addr);
    logic [DATA_W-1:0] rx, exp;
    logic seen;
    if (addr < NUM_CFG) exp = model[addr];
    else if (addr == STAT0_ADDR) exp = {stat0, {PAD_W{1'b0}}};
    else if (addr == STAT1_ADDR) exp = {stat1, {PAD_W{1'b0}}};
    else exp = '0;
    exp_rd_q.push_back(exp);
    exp_strb_q.push_back(ADDR_W'(addr));
    xfer({ADDR_W'(addr), 1'b1, 1'b0, DATA_W'(0)}, FRAME_W, rx, seen);
    got_rd_q.push_back(rx);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_rd_q.size() > 0 && exp_rd_q.size() > 0) begin
      check("R6/R7 readback", 128'(got_rd_q.pop_front()), 128'(exp_rd_q.pop_front()));
    end
    if (rd_strobe) begin
      if (exp_strb_q.size() == 0) check("R8 unexpected strobe", 128'(1), 128'(0));
      else check("R8 strobe address", 128'(rd_addr), 128'(exp_strb_q.pop_front()));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rx;
    logic seen;
    arst_n = 1'b0; sclk = 1'b0; latch_n = 1'b1; mosi = 1'b0;
    stat0 = 6'h2B; stat1 = 6'h3F;
    for (int i = 0; i < NUM_CFG; i++) model[i] = (i >= VOL_LO && i <= VOL_HI) ? 10'h3FF : 10'h000;
    wclk(5);
    arst_n = 1'b1;
    wclk(6);
    check("R1 reset cfg_o", 128'(cfg), 128'(model_flat()));
    check("R9 reset miso", 128'(miso), 128'(0));
    check("R8 reset strobe", 128'(rd_strobe), 128'(0));

    // R2 writes with several patterns and addresses
    do_write("R2 addr0", 0, 10'h3FF, 1'b0, FRAME_W);
    do_write("R2 addr2", 2, 10'h155, 1'b0, FRAME_W);
    do_write("R2 addr10", 10, 10'h2AA, 1'b0, FRAME_W);
    do_write("R2 addr5", 5, 10'h000, 1'b0, FRAME_W);

    // R6 readback of written and reset values
    do_read(2);
    do_read(10);
    do_read(5);
    do_read(7);
    do_read(0);
    check("R6 read leaves cfg_o", 128'(cfg), 128'(model_flat()));

    // R3 wrong bit counts
    do_write("R3 short write", 1, 10'h123, 1'b0, FRAME_W - 1);
    do_write("R3 long write", 1, 10'h321, 1'b0, FRAME_W + 1);
    xfer({4'd3, 1'b1, 1'b0, 10'h0}, 12, rx, seen);
    check("R3 short read", 128'(cfg), 128'(model_flat()));

    // R4 reserved bit set
    do_write("R4 reserved write", 8, 10'h0F0, 1'b1, FRAME_W);
    xfer({4'd2, 1'b1, 1'b1, 10'h0}, FRAME_W, rx, seen);
    check("R4 reserved read miso", 128'(seen), 128'(0));

    // R5 writes to read-only and unused slots
    do_write("R5 addr11", 11, 10'h3C5, 1'b0, FRAME_W);
    do_write("R5 addr12", 12, 10'h1A5, 1'b0, FRAME_W);
    do_write("R5 addr13", 13, 10'h3FF, 1'b0, FRAME_W);
    do_write("R5 addr15", 15, 10'h2DB, 1'b0, FRAME_W);
    do_read(11);

    // R7 status and unused reads
    stat0 = 6'h01;
    stat1 = 6'h20;
    do_read(11);
    do_read(12);
    do_read(13);
    do_read(15);

    wclk(4);
    check("R8 strobes all seen", 128'(exp_strb_q.size()), 128'(0));
    check("R6 readbacks all compared", 128'(exp_rd_q.size()), 128'(0));
    finish_run();
  end

endmodule